// File: doc/BRIEF.md
# Multibit Symmetric FIR Decimator

This block is the second, multibit stage of a two-stage decimating low-pass filter. It takes signed 24-bit words from the preceding stage over a valid/ready stream and keeps them in a circular sample store. Once every decimation period it runs a linear-phase FIR over the most recent window of samples. Each step adds a mirrored pair of samples in a pre-adder, multiplies the sum by one 26-bit entry of a half-length coefficient table, cuts the product to 32 bits and adds it into a 35-bit accumulator. The top 24 accumulator bits are presented on a valid/ready output stream.

The tap count and the rate select are plain control pins. The rate select picks a decimation factor of 4, or 8 for the lowest output rate. The half table is written through a simple write port while the block is idle. On the input side, a word is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while a convolution runs or a result is waiting, so the sender must hold its word until it is taken. On the output side, a result stays on `out_data` with `out_valid` high until the edge where `out_ready` is high. With `out_ready` tied high, `out_valid` is a one-cycle pulse.

Top module: `sym_fir_decim`

## Requirements
- R1: An input word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while a convolution is running, while a result is waiting on the output, and in any cycle where `slow_mode` or `tap_count` differs from its value on the previous edge.
- R2: With `slow_mode`=0, one result is produced for every 4 words taken. With `slow_mode`=1, one result is produced for every 8 words taken.
- R3: Counting restarts after reset or after any change of `slow_mode` or `tap_count`. Words taken since then are numbered m=1,2,…. A result is produced only for an m that is a multiple of the decimation factor and at least `tap_count`, and for no other m.
- R4: For N=`tap_count` (1 to 364), H=ceil(N/2), and x[0] the newest word, the result sums, over k=0..H-1, the term c[k]·(x[k]+x[N-1-k]). Here c[k] is the table entry at address k. When N is odd, the centre term for k=(N-1)/2 uses x[k] once and does not pair it.
- R5: The pre-adder forms the exact 25-bit signed sum of the two 24-bit two's-complement samples.
- R6: The 51-bit signed product is shifted right arithmetically by 19 bits and kept as 32 bits. Low bits are dropped with no rounding.
- R7: Each 32-bit term is sign-extended and added into a 35-bit accumulator that starts at zero and wraps in two's complement without saturating.
- R8: The output word is accumulator bits [34:11]. Lower bits are dropped.
- R9: The edge that takes the word completing a result is edge E. `out_valid` rises after edge E+H.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next edge.
- R11: On an edge where `coef_we` is 1, `coef_data` is stored at table address `coef_addr` (0 to 181). Later results use the stored value.
- R12: After reset, `out_valid` is 0 and `out_data` is 0. Once the control pins have been steady for one edge, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_mode | input | 1 | 0: decimate by 4, 1: decimate by 8 |
| tap_count | input | 9 | Number of FIR taps, 1 to 364 |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 8 | Half-table address |
| coef_data | input | 26 | Signed coefficient to store |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Receiver takes the result |
| out_data | output | 24 | Signed filtered output |

## Verification
A result is due exactly H edges after the edge that takes the word completing its decimation period. The bench notes that edge number when it offers the word and sees `in_ready` high. It then compares the cycle where `out_valid` rises against the stored edge number plus H. All outputs are sampled on the falling edge, after every register on the path has settled. Hold behaviour is checked one edge after each cycle where the output is offered but refused. Results that appear earlier than the window allows are reported as soon as they show up.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sfd_state_e;

  function automatic int half_len(input int taps);
    return (taps + 1) / 2;
  endfunction

endpackage

// File: rtl/sfd_sample_store.sv
module sfd_sample_store #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 364,
  parameter int AGE_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AGE_W-1:0]  age_a,
  input  logic [AGE_W-1:0]  age_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int IW     = ADDR_W + 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wp;

  // slot holding the word 'age' entries older than the newest one
  function automatic logic [ADDR_W-1:0] slot_of(input logic [ADDR_W-1:0] ptr,
                                                input logic [AGE_W-1:0] age);
    logic [IW-1:0] t;
    t = IW'(ptr) + IW'(DEPTH - 1) - IW'(age);
    if (t >= IW'(DEPTH)) t = t - IW'(DEPTH);
    return ADDR_W'(t);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
    end else if (wr_en) begin
      wp <= (wp == ADDR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  assign rd_a = mem[slot_of(wp, age_a)];
  assign rd_b = mem[slot_of(wp, age_b)];

  // R1: write pointer never leaves the store
  assert_ptr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wp < ADDR_W'(DEPTH));

endmodule

// File: rtl/sfd_coef_table.sv
module sfd_coef_table #(
  parameter int COEF_W  = 26,
  parameter int ENTRIES = 182
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] waddr,
  input  logic [COEF_W-1:0]          wdata,
  input  logic [$clog2(ENTRIES)-1:0] raddr,
  output logic [COEF_W-1:0]          rdata
);
  logic [COEF_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R11: writes stay inside the half table
  assert_coef_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < $clog2(ENTRIES)'(ENTRIES)));

endmodule

// File: rtl/sfd_mac.sv
module sfd_mac #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 26,
  parameter int PROD_W = 32,
  parameter int ACC_W  = 35,
  parameter int OUT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              load_out,
  input  logic              pair_en,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  input  logic [COEF_W-1:0] coef,
  output logic [OUT_W-1:0]  out_data
);
  localparam int PRE_W  = DATA_W + 1;
  localparam int FULL_W = PRE_W + COEF_W;
  localparam int SHIFT  = FULL_W - PROD_W;

  logic signed [PRE_W-1:0]  pre;
  logic signed [FULL_W-1:0] prod;
  logic signed [PROD_W-1:0] term;
  logic [ACC_W-1:0]         term_ext;
  logic [ACC_W-1:0]         acc;
  logic [ACC_W-1:0]         acc_sum;

  // pre-adder: centre tap enters alone
  always_comb begin
    pre = $signed({samp_a[DATA_W-1], samp_a});
    if (pair_en) pre = pre + $signed({samp_b[DATA_W-1], samp_b});
  end

  assign prod = FULL_W'(pre) * FULL_W'($signed(coef));
  assign term = PROD_W'(prod >>> SHIFT);

  generate
    if (ACC_W >= PROD_W) begin : g_widen
      assign term_ext = {{(ACC_W-PROD_W){term[PROD_W-1]}}, term};
    end else begin : g_narrow
      assign term_ext = ACC_W'(term);
    end
  endgenerate

  assign acc_sum = acc + term_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      out_data <= '0;
    end else begin
      if (start)     acc <= '0;
      else if (step) acc <= acc_sum;
      if (load_out)  out_data <= OUT_W'(acc_sum >> (ACC_W - OUT_W));
    end
  end

endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl
  import sfd_pkg::*;
#(
  parameter int MAX_TAPS = 364,
  parameter int DEC_FAST = 4,
  parameter int DEC_SLOW = 8,
  parameter int TAP_W    = 9,
  parameter int K_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_mode,
  input  logic [TAP_W-1:0] tap_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             accept,
  output logic             start,
  output logic             step,
  output logic             load_out,
  output logic             pair_en,
  output logic [K_W-1:0]   k_idx,
  output logic [TAP_W-1:0] age_a,
  output logic [TAP_W-1:0] age_b
);
  localparam int PH_W = $clog2(DEC_SLOW);
  localparam int FW   = TAP_W + 1;

  sfd_state_e       state;
  logic [PH_W-1:0]  phase;
  logic [TAP_W-1:0] fill;
  logic             slow_q;
  logic [TAP_W-1:0] taps_q;
  logic             cfg_chg;
  logic             dec_last;
  logic [FW-1:0]    fill_inc;
  logic [FW-1:0]    half;
  logic             last;

  assign cfg_chg  = (slow_mode != slow_q) || (tap_count != taps_q);
  assign in_ready = (state == ST_IDLE) && !out_valid && !cfg_chg;
  assign accept   = in_valid && in_ready;
  assign dec_last = slow_mode ? (phase == PH_W'(DEC_SLOW - 1))
                              : (phase == PH_W'(DEC_FAST - 1));
  assign fill_inc = FW'(fill) + 1'b1;
  assign start    = accept && dec_last && (fill_inc >= FW'(tap_count));
  assign half     = (FW'(tap_count) + 1'b1) >> 1;
  assign last     = (state == ST_RUN) && (FW'(k_idx) == half - 1'b1);
  assign step     = (state == ST_RUN) && !cfg_chg;
  assign load_out = last && !cfg_chg;

  assign age_a   = TAP_W'(k_idx);
  assign age_b   = tap_count - 1'b1 - TAP_W'(k_idx);
  assign pair_en = (age_a != age_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= '0;
      fill      <= '0;
      k_idx     <= '0;
      out_valid <= 1'b0;
      slow_q    <= 1'b0;
      taps_q    <= '0;
    end else begin
      slow_q <= slow_mode;
      taps_q <= tap_count;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (cfg_chg) begin
        state <= ST_IDLE;
        phase <= '0;
        fill  <= '0;
      end else if (accept) begin
        phase <= dec_last ? '0 : phase + 1'b1;
        if (fill_inc <= FW'(MAX_TAPS)) fill <= TAP_W'(fill_inc);
        if (start) begin
          state <= ST_RUN;
          k_idx <= '0;
        end
      end else if (state == ST_RUN) begin
        if (last) begin
          state     <= ST_IDLE;
          out_valid <= 1'b1;
        end else begin
          k_idx <= k_idx + 1'b1;
        end
      end
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_mode && !cfg_chg) |-> (phase < PH_W'(DEC_FAST)));

  assert_step_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (FW'(k_idx) < half));

  assert_result_needs_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (fill >= taps_q));

  assert_result_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state == ST_RUN));

endmodule

// File: rtl/sym_fir_decim.sv
module sym_fir_decim #(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 26,
  parameter int PROD_W   = 32,
  parameter int ACC_W    = 35,
  parameter int OUT_W    = 24,
  parameter int MAX_TAPS = 364,
  parameter int DEC_FAST = 4,
  parameter int DEC_SLOW = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          slow_mode,
  input  logic [$clog2(MAX_TAPS+1)-1:0]                 tap_count,
  input  logic                                          coef_we,
  input  logic [$clog2(sfd_pkg::half_len(MAX_TAPS))-1:0] coef_addr,
  input  logic [COEF_W-1:0]                             coef_data,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [DATA_W-1:0]                             in_data,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [OUT_W-1:0]                              out_data
);
  localparam int HALF_MAX = sfd_pkg::half_len(MAX_TAPS);
  localparam int TAP_W    = $clog2(MAX_TAPS + 1);
  localparam int K_W      = $clog2(HALF_MAX);

  logic              accept, start, step, load_out, pair_en;
  logic [K_W-1:0]    k_idx;
  logic [TAP_W-1:0]  age_a, age_b;
  logic [DATA_W-1:0] samp_a, samp_b;
  logic [COEF_W-1:0] coef;

  sfd_ctrl #(
    .MAX_TAPS(MAX_TAPS), .DEC_FAST(DEC_FAST), .DEC_SLOW(DEC_SLOW),
    .TAP_W(TAP_W), .K_W(K_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .tap_count(tap_count),
    .in_valid(in_valid), .in_ready(in_ready), .out_ready(out_ready),
    .out_valid(out_valid), .accept(accept), .start(start), .step(step),
    .load_out(load_out), .pair_en(pair_en), .k_idx(k_idx),
    .age_a(age_a), .age_b(age_b)
  );

  sfd_sample_store #(.DATA_W(DATA_W), .DEPTH(MAX_TAPS), .AGE_W(TAP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(in_data),
    .age_a(age_a), .age_b(age_b), .rd_a(samp_a), .rd_b(samp_b)
  );

  sfd_coef_table #(.COEF_W(COEF_W), .ENTRIES(HALF_MAX)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
    .wdata(coef_data), .raddr(k_idx), .rdata(coef)
  );

  sfd_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W),
    .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .load_out(load_out), .pair_en(pair_en), .samp_a(samp_a),
    .samp_b(samp_b), .coef(coef), .out_data(out_data)
  );

  assert_hold_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_busy_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !accept);

endmodule

// File: tb/sym_fir_decim_test.sv
`timescale 1ns/1ps
module sym_fir_decim_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_mode = 1'b0;
  logic [8:0]  tap_count = 9'd11;
  logic        coef_we = 1'b0;
  logic [7:0]  coef_addr = '0;
  logic [25:0] coef_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  sym_fir_decim uut (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .tap_count(tap_count),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int nacc = 0;
  int since = 0;
  int cur_taps = 11;
  int cur_dec = 4;
  int seen = 0;
  int want = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  logic [23:0] hist [4096];
  logic [25:0] cf [182];
  logic [23:0] exp_q [$];
  int          exp_cyc_q [$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // expected result per R4..R8
  function automatic logic [23:0] model();
    logic signed [34:0] acc;
    int n;
    int h;
    n = cur_taps;
    h = (n + 1) / 2;
    acc = '0;
    for (int k = 0; k < h; k++) begin
      logic [23:0] a;
      logic [23:0] b;
      logic signed [24:0] pre;
      logic signed [50:0] p;
      logic [31:0] t;
      a = hist[(nacc - 1 - k) % 4096];
      b = (2 * k + 1 == n) ? 24'd0 : hist[(nacc - n + k) % 4096];
      pre = $signed({a[23], a}) + $signed({b[23], b});
      p = 51'(pre) * 51'($signed(cf[k]));
      t = p[50:19];
      acc = acc + $signed({{3{t[31]}}, t});
    end
    return acc[34:11];
  endfunction

  task automatic push(input logic [23:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    while (!in_ready) @(negedge clk);
    hist[nacc % 4096] = d;
    nacc++;
    since++;
    if ((since % cur_dec) == 0 && since >= cur_taps) begin
      exp_q.push_back(model());
      exp_cyc_q.push_back(cyc + 1 + (cur_taps + 1) / 2);
      want++;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit slow, input int taps);
    drain();
    @(negedge clk);
    slow_mode = slow;
    tap_count = 9'(taps);
    cur_dec = slow ? 8 : 4;
    cur_taps = taps;
    since = 0;
    @(negedge clk);
  endtask

  // kind 0 random, 1 most negative, 2 most positive
  task automatic load_coefs(input int kind);
    for (int i = 0; i < (cur_taps + 1) / 2; i++) begin
      logic [25:0] v;
      v = (kind == 1) ? 26'h2000000 : (kind == 2) ? 26'h1FFFFFF : 26'($urandom);
      cf[i] = v;
      @(negedge clk);
      coef_we = 1'b1;
      coef_addr = 8'(i);
      coef_data = v;
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // result monitor
  logic        prev_ov = 1'b0;
  logic        prev_rdy = 1'b1;
  logic [23:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !prev_ov) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected result", out_data, 0);
        end else begin
          check(cyc == exp_cyc_q[0], "R9", "result cycle", cyc, exp_cyc_q[0]);
          check(out_data == exp_q[0], "R4/R6/R7/R8", "result value", out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(exp_cyc_q.pop_front());
        end
      end
      if (prev_ov && !prev_rdy) begin
        check(out_valid == 1'b1, "R10", "valid held", out_valid, 1);
        check(out_data == prev_data, "R10", "data held", out_data, prev_data);
        check(in_ready == 1'b0, "R1", "input blocked while pending", in_ready, 0);
      end
    end
    prev_ov = out_valid;
    prev_rdy = out_ready;
    prev_data = out_data;
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    check(out_data == 24'd0, "R12", "out_data after reset", out_data, 0);
    check(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);

    // R2 R4 R11: odd taps, factor 4, random data
    load_coefs(0);
    for (int i = 0; i < 10; i++) push(24'($urandom));
    check(seen == 0, "R3", "no result before window full", seen, 0);
    for (int i = 0; i < 50; i++) push(24'($urandom));
    drain();
    check(seen == want, "R2", "result count odd taps", seen, want);

    // R5: even taps, mirrored pairs, then in_ready blocked on change (R1)
    @(negedge clk);
    tap_count = 9'd8;
    #0.1 check(in_ready == 1'b0, "R1", "in_ready on config change", in_ready, 0);
    cur_taps = 8; cur_dec = 4; since = 0;
    @(negedge clk);
    load_coefs(0);
    for (int i = 0; i < 40; i++) push(($urandom % 2) ? 24'h7FFFFF : 24'($urandom));
    drain();
    check(seen == want, "R2", "result count even taps", seen, want);

    // R10: back-pressure on output
    bp_mode = 1'b1;
    for (int i = 0; i < 60; i++) push(24'($urandom));
    drain();
    bp_mode = 1'b0;
    check(seen == want, "R10", "result count with back-pressure", seen, want);

    // R2 R3: factor 8 restarts counting
    set_cfg(1'b1, 20);
    load_coefs(0);
    w0 = seen;
    for (int i = 0; i < 23; i++) push(24'($urandom));
    drain();
    check(seen == w0, "R3", "no result below a full window", seen, w0);
    push(24'($urandom));
    drain();
    check(seen == w0 + 1, "R2", "first factor-8 result at 24", seen, w0 + 1);
    for (int i = 0; i < 40; i++) push(24'($urandom));
    drain();
    check(seen == want, "R2", "result count factor 8", seen, want);

    // R1 tap count 1: centre only
    set_cfg(1'b0, 1);
    load_coefs(0);
    for (int i = 0; i < 12; i++) push(24'($urandom));
    drain();
    check(seen == want, "R4", "single tap result count", seen, want);

    // R7: full window, extreme negative values, accumulator wraps
    set_cfg(1'b1, 364);
    load_coefs(1);
    for (int i = 0; i < 368; i++) push(24'h800000);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check(out_data == 24'hB00000, "R7", "wrapped accumulator", out_data, 24'hB00000);
    drain();

    // R6 R8: extreme positive
    load_coefs(2);
    for (int i = 0; i < 16; i++) push(24'h7FFFFF);
    drain();
    check(seen == want, "R8", "result count full window", seen, want);
    check(exp_q.size() == 0, "R3", "no missing results", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule